// File: doc/BRIEF.md
# Paged SPI Register Target

This block is a serial-peripheral slave that fronts a small register file split into pages. A host opens a frame by pulling chip select low and sends a command byte whose top bit says read (1) or write (0) and whose low seven bits name a register inside the current page. Register 0x01 holds the page number. The sixteen addresses 0x00 to 0x0F reach the same common registers on every page. The page number and the address together pick the register and also its data width, one byte or two. After the command byte the block either shifts the register out on MISO, most-significant bit first, or collects write data, which it commits when chip select rises.

The common registers are a no-op slot, the page number, a conversion-command word, a one-byte result, a one-byte converter-enable mask, a fixed identity word and a keyed reset word. Page 0x00 holds measurement words, which are preloaded from a side port, and converter code words. Page 0x02 holds setting words and page 0x0E holds one-byte offset trims. The serial pins are sampled with the system clock, so SCLK must run well below it. Every register in the file is storage only: the block has no analog function.

Top module: `paged_spi_target`

## Requirements
- R1: SPI mode 0. MOSI is taken on rising SCLK, most-significant bit first. Command bit 7 = 1 means read and bit 7 = 0 means write. Command bits 6:0 are the address within the current page.
- R2: MISO is 0 while chip select is high and during the eight command bits. On a read, the first data bit is driven at the falling SCLK edge that follows the eighth command bit, and each later falling edge shifts out the next bit.
- R3: Address 0x01 is the page register, one byte wide and readable. Addresses 0x00 to 0x0F decode the same on every page. Only addresses at 0x10 and above depend on the page.
- R4: Widths. These are two bytes wide: 0x02 (conversion command), 0x0C (identity), 0x0F (reset key), page 0x00 measurement words 0x10+i and converter words 0x30+i, and page 0x02 setting words 0x10+i. These are one byte wide: 0x00, 0x01, 0x03 (result), 0x04 (enable mask), page 0x0E offsets 0x10+i, and every unimplemented address. Here i runs from 0 to the channel count minus 1, which is 4 by default.
- R5: Two-byte values travel high byte first. A one-byte value fills the first data byte. Any bits clocked beyond the register width read as 0.
- R6: A read of 0x0C returns 0x0018, and writes to it have no effect.
- R7: Measurement and converter words keep a 12-bit value in bits 15:4, and bits 3:0 read as 0. Measurement words are loaded only through the side port (ld_en, ld_idx, 12-bit ld_val). SPI writes to them are ignored.
- R8: Setting words, offsets, the conversion-command word, the result byte and the enable mask read back what was last written. Their reset value is 0.
- R9: A write to an unimplemented address changes nothing. A read of an unimplemented address returns 0.
- R10: A write takes effect only if at least the full data width was clocked in before chip select rose. Bits clocked in beyond the width are ignored.
- R11: Writing 0x7293 to 0x0F and then writing 0x0000 to 0x0F returns every register to its reset value, and the page returns to 0. A read of 0x0F returns 0.
- R12: A write of any value other than 0x7293 or 0x0000 to 0x0F, made after 0x7293, cancels the key, so a later 0x0000 does not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| ld_en | input | 1 | Side-port load strobe for a measurement word |
| ld_idx | input | CH_IDX_W | Measurement word index |
| ld_val | input | 12 | 12-bit measurement value |

## Verification
The hardest situations to reach from the pins are frames that end at an awkward bit count: chip select rising in the middle of a data byte, frames that carry extra bits past the register width, and key writes interleaved with a cancelling value. The bench drives every frame through one transfer task that takes an explicit bit count. This lets it cut a frame short, lengthen it or stop after the command byte. A sweep then reads every address on three pages and part of an unused page, and compares each read against values computed from the write patterns.

// File: rtl/paged_spi_pkg.sv
`timescale 1ns/1ps
package paged_spi_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_NOOP, RK_PAGE, RK_CONV, RK_RES, RK_DACEN,
    RK_ID, RK_KEY, RK_MEAS, RK_DAC, RK_SET, RK_OFS
  } reg_kind_e;

  localparam logic [15:0] ID_WORD   = 16'h0018;
  localparam logic [15:0] KEY_ARM   = 16'h7293;
  localparam logic [15:0] KEY_FIRE  = 16'h0000;

  localparam logic [7:0] PG_DATA = 8'h00;
  localparam logic [7:0] PG_SET  = 8'h02;
  localparam logic [7:0] PG_OFS  = 8'h0E;

  localparam logic [6:0] BASE_MEAS = 7'h10;
  localparam logic [6:0] BASE_DAC  = 7'h30;
  localparam logic [6:0] BASE_SET  = 7'h10;
  localparam logic [6:0] BASE_OFS  = 7'h10;

  function automatic logic in_window(input logic [6:0] addr, input logic [6:0] base,
                                     input int nch);
    return (int'(addr) >= int'(base)) && (int'(addr) < int'(base) + nch);
  endfunction

  // Page + address -> register kind; addresses below 0x10 ignore the page.
  function automatic reg_kind_e decode_kind(input logic [7:0] page, input logic [6:0] addr,
                                            input int nch);
    reg_kind_e k;
    k = RK_NONE;
    if (addr < 7'h10) begin
      case (addr[3:0])
        4'h0:    k = RK_NOOP;
        4'h1:    k = RK_PAGE;
        4'h2:    k = RK_CONV;
        4'h3:    k = RK_RES;
        4'h4:    k = RK_DACEN;
        4'hC:    k = RK_ID;
        4'hF:    k = RK_KEY;
        default: k = RK_NONE;
      endcase
    end else if (page == PG_DATA && in_window(addr, BASE_MEAS, nch)) begin
      k = RK_MEAS;
    end else if (page == PG_DATA && in_window(addr, BASE_DAC, nch)) begin
      k = RK_DAC;
    end else if (page == PG_SET && in_window(addr, BASE_SET, nch)) begin
      k = RK_SET;
    end else if (page == PG_OFS && in_window(addr, BASE_OFS, nch)) begin
      k = RK_OFS;
    end
    return k;
  endfunction

  function automatic logic kind_is_wide(input reg_kind_e k);
    case (k)
      RK_CONV, RK_ID, RK_KEY, RK_MEAS, RK_DAC, RK_SET: return 1'b1;
      default:                                        return 1'b0;
    endcase
  endfunction

  function automatic logic [6:0] win_offset(input reg_kind_e k, input logic [6:0] addr);
    case (k)
      RK_MEAS: return addr - BASE_MEAS;
      RK_DAC:  return addr - BASE_DAC;
      RK_SET:  return addr - BASE_SET;
      RK_OFS:  return addr - BASE_OFS;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_frame_eng.sv
`timescale 1ns/1ps
module spi_frame_eng (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        cs_n_i,
  input  logic        mosi_i,
  input  logic        dec_wide_i,
  input  logic [15:0] rd_word_i,
  output logic [7:0]  cmd_now_o,
  output logic        wr_evt_o,
  output logic [6:0]  wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        frame_act_o,
  output logic        miso_o
);
  localparam int CMD_BITS  = 8;
  localparam int BYTE_BITS = 8;
  localparam int MAX_BITS  = CMD_BITS + 2 * BYTE_BITS;
  localparam int CW        = $clog2(MAX_BITS + 1);
  localparam logic [CW-1:0] CNT_LAST_CMD = CW'(CMD_BITS - 1);
  localparam logic [CW-1:0] CNT_CMD      = CW'(CMD_BITS);
  localparam logic [CW-1:0] CNT_SHORT    = CW'(CMD_BITS + BYTE_BITS);
  localparam logic [CW-1:0] CNT_LONG     = CW'(MAX_BITS);

  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  logic       sclk_rise, sclk_fall, cs_end;

  logic [CW-1:0] bit_cnt;
  logic [6:0]    cmd_sr, addr_q;
  logic [15:0]   rx_sr, tx_sr;
  logic          is_rd, wide_q, miso_q;
  logic [CW-1:0] frame_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[1:0], cs_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end
  end

  assign sclk_rise   = sclk_s[1] & ~sclk_s[2];
  assign sclk_fall   = ~sclk_s[1] & sclk_s[2];
  assign frame_act_o = ~cs_s[1];
  assign cs_end      = cs_s[1] & ~cs_s[2];
  assign frame_bits  = wide_q ? CNT_LONG : CNT_SHORT;
  assign cmd_now_o   = {cmd_sr, mosi_s[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      cmd_sr  <= '0;
      addr_q  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      is_rd   <= 1'b0;
      wide_q  <= 1'b0;
      miso_q  <= 1'b0;
    end else if (!frame_act_o) begin
      bit_cnt <= '0;
      is_rd   <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      if (sclk_rise) begin
        if (bit_cnt < CNT_CMD) cmd_sr <= cmd_now_o[6:0];
        if (bit_cnt == CNT_LAST_CMD) begin
          is_rd  <= cmd_now_o[7];
          addr_q <= cmd_now_o[6:0];
          wide_q <= dec_wide_i;
          tx_sr  <= dec_wide_i ? rd_word_i : {rd_word_i[7:0], 8'h00};
        end
        if (bit_cnt >= CNT_CMD && bit_cnt < frame_bits) rx_sr <= {rx_sr[14:0], mosi_s[1]};
        if (bit_cnt < CNT_LONG) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) begin
        if (is_rd && bit_cnt >= CNT_CMD) begin
          miso_q <= tx_sr[15];
          tx_sr  <= {tx_sr[14:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  assign wr_evt_o  = cs_end && !is_rd && (bit_cnt >= frame_bits);
  assign wr_addr_o = addr_q;
  assign wr_data_o = wide_q ? rx_sr : {8'h00, rx_sr[7:0]};
  assign miso_o    = miso_q;

endmodule

// File: rtl/paged_regs.sv
`timescale 1ns/1ps
module paged_regs
  import paged_spi_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       rd_addr,
  output logic [15:0]      rd_word_o,
  output logic             rd_wide_o,
  input  logic             wr_evt,
  input  logic [6:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [11:0]      ld_val,
  output logic [7:0]       page_o,
  output logic             key_arm_o,
  output logic             soft_rst_o
);
  localparam int NCH = 1 << IDX_W;

  logic [7:0]  page_q, res_q, dacen_q;
  logic [15:0] conv_q;
  logic        key_arm;

  reg_kind_e        wk, rk;
  logic [IDX_W-1:0] wi, ri;
  logic             soft_rst;

  logic [15:0] meas_w [NCH];
  logic [15:0] dac_w  [NCH];
  logic [15:0] set_w  [NCH];
  logic [7:0]  ofs_w  [NCH];

  assign wk = decode_kind(page_q, wr_addr, NCH);
  assign wi = IDX_W'(win_offset(wk, wr_addr));
  assign rk = decode_kind(page_q, rd_addr, NCH);
  assign ri = IDX_W'(win_offset(rk, rd_addr));

  assign soft_rst = wr_evt && (wk == RK_KEY) && key_arm && (wr_data == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      res_q   <= '0;
      dacen_q <= '0;
      conv_q  <= '0;
      key_arm <= 1'b0;
    end else if (soft_rst) begin
      page_q  <= '0;
      res_q   <= '0;
      dacen_q <= '0;
      conv_q  <= '0;
      key_arm <= 1'b0;
    end else if (wr_evt) begin
      case (wk)
        RK_PAGE:  page_q  <= wr_data[7:0];
        RK_CONV:  conv_q  <= wr_data;
        RK_RES:   res_q   <= wr_data[7:0];
        RK_DACEN: dacen_q <= wr_data[7:0];
        RK_KEY:   key_arm <= (wr_data == KEY_ARM);
        default:  ;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [11:0] meas_q, dac_q;
    logic [15:0] set_q;
    logic [7:0]  ofs_q;
    logic        hit;

    assign hit = wr_evt && (wi == IDX_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meas_q <= '0;
        dac_q  <= '0;
        set_q  <= '0;
        ofs_q  <= '0;
      end else if (soft_rst) begin
        meas_q <= '0;
        dac_q  <= '0;
        set_q  <= '0;
        ofs_q  <= '0;
      end else begin
        if (ld_en && ld_idx == IDX_W'(c)) meas_q <= ld_val;
        if (hit) begin
          case (wk)
            RK_DAC:  dac_q <= wr_data[15:4];
            RK_SET:  set_q <= wr_data;
            RK_OFS:  ofs_q <= wr_data[7:0];
            default: ;
          endcase
        end
      end
    end

    assign meas_w[c] = {meas_q, 4'h0};
    assign dac_w[c]  = {dac_q, 4'h0};
    assign set_w[c]  = set_q;
    assign ofs_w[c]  = ofs_q;
  end

  always_comb begin
    case (rk)
      RK_PAGE:  rd_word_o = {8'h00, page_q};
      RK_CONV:  rd_word_o = conv_q;
      RK_RES:   rd_word_o = {8'h00, res_q};
      RK_DACEN: rd_word_o = {8'h00, dacen_q};
      RK_ID:    rd_word_o = ID_WORD;
      RK_MEAS:  rd_word_o = meas_w[ri];
      RK_DAC:   rd_word_o = dac_w[ri];
      RK_SET:   rd_word_o = set_w[ri];
      RK_OFS:   rd_word_o = {8'h00, ofs_w[ri]};
      default:  rd_word_o = 16'h0000;
    endcase
  end

  assign rd_wide_o  = kind_is_wide(rk);
  assign page_o     = page_q;
  assign key_arm_o  = key_arm;
  assign soft_rst_o = soft_rst;

endmodule

// File: rtl/paged_spi_target.sv
`timescale 1ns/1ps
module paged_spi_target #(
  parameter int CH_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic                ld_en,
  input  logic [CH_IDX_W-1:0] ld_idx,
  input  logic [11:0]         ld_val
);
  logic [7:0]  cmd_now;
  logic        wr_evt;
  logic [6:0]  wr_addr;
  logic [15:0] wr_data;
  logic        frame_act;
  logic [15:0] rd_word;
  logic        rd_wide;
  logic [7:0]  cur_page;
  logic        key_armed;
  logic        soft_rst;

  spi_frame_eng u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (spi_sclk),
    .cs_n_i      (spi_cs_n),
    .mosi_i      (spi_mosi),
    .dec_wide_i  (rd_wide),
    .rd_word_i   (rd_word),
    .cmd_now_o   (cmd_now),
    .wr_evt_o    (wr_evt),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .frame_act_o (frame_act),
    .miso_o      (spi_miso)
  );

  paged_regs #(.IDX_W(CH_IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr    (cmd_now[6:0]),
    .rd_word_o  (rd_word),
    .rd_wide_o  (rd_wide),
    .wr_evt     (wr_evt),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ld_en      (ld_en),
    .ld_idx     (ld_idx),
    .ld_val     (ld_val),
    .page_o     (cur_page),
    .key_arm_o  (key_armed),
    .soft_rst_o (soft_rst)
  );

endmodule

// File: rtl/paged_spi_target_chk.sv
`timescale 1ns/1ps
module paged_spi_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_act,
  input logic       spi_miso,
  input logic       wr_evt,
  input logic       soft_rst,
  input logic [7:0] cur_page,
  input logic       key_armed
);
  assert_miso_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !spi_miso);

  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(cur_page));

  assert_reset_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> wr_evt);

  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cur_page == 8'h00) && !key_armed);

  assert_key_from_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_armed) |-> $past(wr_evt));
endmodule

bind paged_spi_target paged_spi_target_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_act (frame_act),
  .spi_miso  (spi_miso),
  .wr_evt    (wr_evt),
  .soft_rst  (soft_rst),
  .cur_page  (cur_page),
  .key_armed (key_armed)
);

// File: tb/paged_spi_target_tb_top.sv
`timescale 1ns/1ps
module paged_spi_target_tb_top;
  localparam int HALF = 5;
  localparam int NCH  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic ld_en = 1'b0;
  logic [1:0] ld_idx = '0;
  logic [11:0] ld_val = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  paged_spi_target dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val)
  );

  // Patterns written before the sweep
  function automatic logic [11:0] p_meas(input int i); return 12'hF00 - 12'(i * 'h0F1); endfunction
  function automatic logic [15:0] p_dac(input int i);  return 16'h3C0F + 16'(i * 'h1111); endfunction
  function automatic logic [15:0] p_set(input int i);  return 16'hA5C3 ^ 16'(i * 'h0101); endfunction
  function automatic logic [7:0]  p_ofs(input int i);  return 8'h80 + 8'(i * 'h0B); endfunction
  localparam logic [15:0] P_CONV = 16'hBEEF;
  localparam logic [7:0]  P_RES = 8'h5D, P_DACEN = 8'h0F;

  // Expected 16-bit read after the pattern load (one-byte registers land in the high byte)
  function automatic logic [15:0] exp_read(input int pg, input int a);
    if (a == 1) return {8'(pg), 8'h00};
    if (a == 2) return P_CONV;
    if (a == 3) return {P_RES, 8'h00};
    if (a == 4) return {P_DACEN, 8'h00};
    if (a == 12) return 16'h0018;
    if (a < 16) return 16'h0000;
    if (pg == 0 && a >= 16 && a < 16 + NCH) return {p_meas(a - 16), 4'h0};
    if (pg == 0 && a >= 48 && a < 48 + NCH) return p_dac(a - 48) & 16'hFFF0;
    if (pg == 2 && a >= 16 && a < 16 + NCH) return p_set(a - 16);
    if (pg == 14 && a >= 16 && a < 16 + NCH) return {p_ofs(a - 16), 8'h00};
    return 16'h0000;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbits, input logic [23:0] txd,
                      output logic [23:0] rxd, output logic [7:0] cmd_rx);
    logic [31:0] frame;
    logic [31:0] got;
    frame = {cmd, txd};
    got = '0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 8 + nbits; i++) begin
      mosi = frame[31 - i];
      wait_clk(HALF);
      got[31 - i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2 * HALF);
    rxd = got[23:0];
    cmd_rx = got[31:24];
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] b);
    logic [23:0] r; logic [7:0] c;
    xfer({1'b0, a}, 8, {b, 16'h0}, r, c);
  endtask

  task automatic wr2(input logic [6:0] a, input logic [15:0] w);
    logic [23:0] r; logic [7:0] c;
    xfer({1'b0, a}, 16, {w, 8'h0}, r, c);
  endtask

  task automatic rd16(input logic [6:0] a, output logic [15:0] v);
    logic [23:0] r; logic [7:0] c;
    xfer({1'b1, a}, 16, 24'h0, r, c);
    v = r[23:8];
  endtask

  task automatic load_meas(input int i, input logic [11:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 2'(i); ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    logic [23:0] r;
    logic [7:0]  c;

    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(5);

    // Reset state
    check({23'h0, miso}, 24'h0, "R2 idle miso");
    xfer({1'b1, 7'h0C}, 16, 24'h0, r, c);
    check({16'h0, c}, 24'h0, "R2 miso zero in command byte");
    check(r, 24'h001800, "R6 identity read");
    rd16(7'h01, v); check({8'h0, v}, 24'h0, "R3 page reset value");
    rd16(7'h02, v); check({8'h0, v}, 24'h0, "R8 conversion word reset value");

    // One-byte offset write/read on page 0x0E
    wr1(7'h01, 8'h0E);
    rd16(7'h01, v); check({8'h0, v}, 24'h000E00, "R3 page readback");
    wr1(7'h11, 8'h6B);
    rd16(7'h11, v); check({8'h0, v}, 24'h006B00, "R1 offset write then read");
    xfer({1'b1, 7'h11}, 16, 24'h0, r, c);
    check(r, 24'h6B0000, "R5 bits past one-byte width read zero");
    rd16(7'h0C, v); check({8'h0, v}, 24'h000018, "R3 common identity on page 0x0E");
    xfer({1'b0, 7'h12}, 0, 24'h0, r, c);
    rd16(7'h12, v); check({8'h0, v}, 24'h0, "R10 command-only write discarded");

    // Page 0x02 settings: short and long writes
    wr1(7'h01, 8'h02);
    xfer({1'b0, 7'h10}, 8, 24'hAA0000, r, c);
    rd16(7'h10, v); check({8'h0, v}, 24'h0, "R10 half-width write discarded");
    xfer({1'b0, 7'h10}, 24, 24'h13579B, r, c);
    rd16(7'h10, v); check({8'h0, v}, 24'h001357, "R10 extra bits ignored");
    wr2(7'h11, 16'hC3A5);
    xfer({1'b1, 7'h11}, 16, 24'h0, r, c);
    check(r, 24'hC3A500, "R5 high byte first");

    // Identity is read-only
    wr2(7'h0C, 16'hFFFF);
    rd16(7'h0C, v); check({8'h0, v}, 24'h000018, "R6 identity write ignored");

    // Page 0x00 data words
    wr1(7'h01, 8'h00);
    wr2(7'h10, 16'hFFFF);
    rd16(7'h10, v); check({8'h0, v}, 24'h0, "R7 measurement SPI write ignored");
    wr2(7'h30, 16'hABCD);
    rd16(7'h30, v); check({8'h0, v}, 24'h00ABC0, "R7 converter word low nibble zero");
    load_meas(2, 12'h9A5);
    rd16(7'h12, v); check({8'h0, v}, 24'h009A50, "R7 side-port load");

    // Unimplemented addresses
    wr2(7'h20, 16'h1111);
    rd16(7'h20, v); check({8'h0, v}, 24'h0, "R9 unimplemented page 0 address");
    wr1(7'h01, 8'h03);
    wr2(7'h10, 16'h2222);
    rd16(7'h10, v); check({8'h0, v}, 24'h0, "R9 unimplemented page 3 address");

    // Key cancelled by another value
    wr1(7'h01, 8'h02);
    wr2(7'h13, 16'h4444);
    wr2(7'h0F, 16'h7293);
    wr2(7'h0F, 16'h1234);
    wr2(7'h0F, 16'h0000);
    rd16(7'h01, v); check({8'h0, v}, 24'h000200, "R12 page kept after cancelled key");
    rd16(7'h13, v); check({8'h0, v}, 24'h004444, "R12 setting kept after cancelled key");
    rd16(7'h0F, v); check({8'h0, v}, 24'h0, "R11 key register reads zero");

    // Pattern load for the sweep
    for (int i = 0; i < NCH; i++) load_meas(i, p_meas(i));
    wr1(7'h01, 8'h00);
    for (int i = 0; i < NCH; i++) wr2(7'(48 + i), p_dac(i));
    wr1(7'h01, 8'h02);
    for (int i = 0; i < NCH; i++) wr2(7'(16 + i), p_set(i));
    wr1(7'h01, 8'h0E);
    for (int i = 0; i < NCH; i++) wr1(7'(16 + i), p_ofs(i));
    wr2(7'h02, P_CONV);
    wr1(7'h03, P_RES);
    wr1(7'h04, P_DACEN);

    // Sweep: pages 0, 2, 0x0E fully; page 3 low addresses
    for (int p = 0; p < 4; p++) begin
      int pg;
      int top;
      pg  = (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 14 : 3;
      top = (p == 3) ? 32 : 128;
      wr1(7'h01, 8'(pg));
      for (int a = 0; a < top; a++) begin
        rd16(7'(a), v);
        check({8'h0, v}, {8'h0, exp_read(pg, a)}, "R3 R4 R5 R7 R8 R9 sweep");
      end
    end

    // Full key sequence
    wr2(7'h0F, 16'h7293);
    wr2(7'h0F, 16'h0000);
    rd16(7'h01, v); check({8'h0, v}, 24'h0, "R11 page back to zero");
    rd16(7'h02, v); check({8'h0, v}, 24'h0, "R11 conversion word cleared");
    rd16(7'h10, v); check({8'h0, v}, 24'h0, "R11 measurement word cleared");
    wr1(7'h01, 8'h02);
    rd16(7'h10, v); check({8'h0, v}, 24'h0, "R11 setting word cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule